// File: doc/BRIEF.md
# Multi-Select Static RAM Array

A 128-word by 8-bit storage array that sits on a shared data bus. The bus is modelled as three signals: a data input, a data output and an output enable that marks when the block drives the bus. Five enable inputs gate the array. Two of them are active high and three are active low. The array responds only when all five agree. Separate active-low read and write strobes then pick what the array does.

The select inputs and the two strobes decode to one of four modes. In read mode the block drives the stored word onto the bus. In write mode it takes the bus value into the addressed word on the clock edge. In standby it does nothing. When not selected it also does nothing, and the strobes have no effect.

Read data passes through a register, so a read presents its word one clock after the address and strobe are applied. The output enable falls in the same cycle that the read stops being valid.

Top module: `msram`

## Requirements
- R1: The array holds 128 words of 8 bits on a 7-bit address. A word written to an address is returned by a later read of that address.
- R2: The array is selected only when `en_a` = 1, `en_b` = 1, `en_c_n` = 0, `en_d_n` = 0 and `en_e_n` = 0. With any other combination, `dout_oe` stays 0 whatever the strobes do.
- R3: When the array is selected with `rd_n` = 0 and the same address is held across a rising clock edge, `dout_oe` is 1 after that edge and `dout` equals the word at that address.
- R4: When the array is selected with `rd_n` = 1 and `wr_n` = 0, `din` is stored at `addr` on the rising clock edge, and `dout_oe` stays 0.
- R5: When the array is selected with both strobes at 1 (standby), `dout_oe` stays 0 and no word changes.
- R6: When the array is selected with both strobes at 0, the cycle is a read. No word is written.
- R7: While the array is not selected, a low `wr_n` stores nothing.
- R8: `dout_oe` falls without waiting for a clock edge when `rd_n` rises, when the array is deselected, or when `addr` changes. After an address change it returns one clock later with the new word.
- R9: `dout` reads 0 whenever `dout_oe` is 0.
- R10: While `rst_n` is low, and after reset until the first valid read, `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 7 | Word address |
| en_a | input | 1 | Select enable, active high |
| en_b | input | 1 | Select enable, active high |
| en_c_n | input | 1 | Select enable, active low |
| en_d_n | input | 1 | Select enable, active low |
| en_e_n | input | 1 | Select enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Bus value to store |
| dout | output | 8 | Bus value being driven |
| dout_oe | output | 1 | Bus drive enable |

## Verification
The properties assume that the address, the selects and the strobes change only between clock edges, so that each edge samples one settled mode. They also assume that no location is read before it has been written. The bench changes every input on the falling clock edge. It fills all 128 words before it reads any of them, and it samples the outputs one nanosecond after the rising edge.

// File: rtl/msram.sv
module msram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          en_c_n,
  input  logic          en_d_n,
  input  logic          en_e_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {M_OFF, M_IDLE, M_WRITE, M_READ} mode_t;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic          chosen;
  mode_t         mode;

  assign chosen = en_a & en_b & ~en_c_n & ~en_d_n & ~en_e_n;

  always_comb begin
    if (!chosen)     mode = M_OFF;
    else if (!rd_n)  mode = M_READ;
    else if (!wr_n)  mode = M_WRITE;
    else             mode = M_IDLE;
  end

  always_ff @(posedge clk)
    if (mode == M_WRITE) mem[addr] <= din;

  always_ff @(posedge clk) begin
    rdata_q <= mem[addr];
    addr_q  <= addr;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= (mode == M_READ);

  assign dout_oe = rd_q & (mode == M_READ) & (addr_q == addr);
  assign dout    = dout_oe ? rdata_q : '0;
endmodule

// File: rtl/msram_props.sv
module msram_props #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          en_a,
  input logic          en_b,
  input logic          en_c_n,
  input logic          en_d_n,
  input logic          en_e_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] dout,
  input logic          dout_oe
);
  logic sel, armed;
  assign sel = en_a & en_b & ~en_c_n & ~en_d_n & ~en_e_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !dout_oe);

  a_r4_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && !wr_n) |-> !dout_oe);

  a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> !dout_oe);

  a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sel && !rd_n && $past(sel && !rd_n) && $stable(addr)) |-> dout_oe);

  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

  always_comb
    if (!rst_n) a_r10_reset_off: assert (!dout_oe);
endmodule

bind msram msram_props #(.AW(AW), .DW(DW)) u_props (
  .clk(clk), .rst_n(rst_n), .addr(addr), .en_a(en_a), .en_b(en_b),
  .en_c_n(en_c_n), .en_d_n(en_d_n), .en_e_n(en_e_n), .rd_n(rd_n),
  .wr_n(wr_n), .dout(dout), .dout_oe(dout_oe));

// File: tb/msram_test.sv
module msram_test;
  logic       clk = 0, rst_n = 0;
  logic [6:0] addr = '0;
  logic       en_a = 0, en_b = 0, en_c_n = 1, en_d_n = 1, en_e_n = 1;
  logic       rd_n = 1, wr_n = 1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;
  logic [7:0] model [128];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msram uut (.clk(clk), .rst_n(rst_n), .addr(addr), .en_a(en_a), .en_b(en_b),
    .en_c_n(en_c_n), .en_d_n(en_d_n), .en_e_n(en_e_n), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .dout(dout), .dout_oe(dout_oe));

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit index: 0 en_a, 1 en_b, 2 en_c_n, 3 en_d_n, 4 en_e_n; spoil<0 selects
  task automatic set_sel(int spoil);
    en_a = 1; en_b = 1; en_c_n = 0; en_d_n = 0; en_e_n = 0;
    case (spoil)
      0: en_a = 0;
      1: en_b = 0;
      2: en_c_n = 1;
      3: en_d_n = 1;
      4: en_e_n = 1;
      default: ;
    endcase
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    set_sel(-1); addr = a; din = d; rd_n = 1; wr_n = 0;
    @(posedge clk); #1;
    chk("R4 oe during write", {dout_oe, 8'h0}, 9'h0);
    model[a] = d;
    @(negedge clk); wr_n = 1;
  endtask

  task automatic rd(logic [6:0] a, string req);
    @(negedge clk);
    set_sel(-1); addr = a; rd_n = 0; wr_n = 1;
    @(posedge clk); #1;
    chk(req, {dout_oe, dout}, {1'b1, model[a]});
    @(negedge clk); rd_n = 1;
  endtask

  task automatic t_reset;
    #1 chk("R10 oe in reset", {dout_oe, dout}, 9'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R10 oe after reset", {dout_oe, dout}, 9'h0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 128; i++) wr(7'(i), 8'((i * 29 + 7) ^ 8'h5A));
    for (int i = 0; i < 128; i++) rd(7'(i), "R1 R3 readback");
  endtask

  task automatic t_standby;
    @(negedge clk); set_sel(-1); addr = 7'd9; din = 8'hEE; rd_n = 1; wr_n = 1;
    repeat (3) begin
      @(posedge clk); #1;
      chk("R5 R9 standby silent", {dout_oe, dout}, 9'h0);
    end
    rd(7'd9, "R5 standby keeps word");
  endtask

  task automatic t_deselect;
    for (int s = 0; s < 5; s++) begin
      @(negedge clk); set_sel(s); addr = 7'(20 + s); rd_n = 0; wr_n = 1;
      @(posedge clk); #1;
      chk("R2 deselected read", {dout_oe, dout}, 9'h0);
      @(negedge clk); rd_n = 1; wr_n = 0; din = ~model[20 + s];
      @(posedge clk); #1;
      @(negedge clk); wr_n = 1;
      rd(7'(20 + s), "R7 deselected write ignored");
    end
  endtask

  task automatic t_both_low;
    @(negedge clk); set_sel(-1); addr = 7'd33; din = ~model[33]; rd_n = 0; wr_n = 0;
    @(posedge clk); #1;
    chk("R6 both low reads", {dout_oe, dout}, {1'b1, model[33]});
    @(negedge clk); rd_n = 1; wr_n = 1;
    rd(7'd33, "R6 no write");
  endtask

  task automatic t_drop;
    @(negedge clk); set_sel(-1); addr = 7'd40; rd_n = 0; wr_n = 1;
    @(posedge clk); #1;
    chk("R3 read", {dout_oe, dout}, {1'b1, model[40]});
    @(negedge clk); addr = 7'd41; #1;
    chk("R8 addr change drops", {dout_oe, dout}, 9'h0);
    @(posedge clk); #1;
    chk("R8 new word next clock", {dout_oe, dout}, {1'b1, model[41]});
    @(negedge clk); rd_n = 1; #1;
    chk("R8 strobe rise drops", {dout_oe, dout}, 9'h0);
    rd_n = 0;
    @(posedge clk); #1;
    @(negedge clk); en_d_n = 1; #1;
    chk("R8 deselect drops", {dout_oe, dout}, 9'h0);
    rd_n = 1; en_d_n = 0;
  endtask

  initial begin
    t_reset();
    t_fill();
    t_standby();
    t_deselect();
    t_both_low();
    t_drop();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule